// File: doc/BRIEF.md
# Instruction Fetch Queue Buffer

This block sits between a processor's 32-bit instruction bus and its decoder. It stores up to three bus words as six halfword slots. It hands the decoder one instruction at a time, either 16 or 32 bits wide, whichever the instruction's encoding requires. Because a wide instruction may start in the upper half of one word and end in the lower half of the next, the queue works in halfwords. It is filled one word per bus response.

While there is room, the block keeps asking for the next sequential word, so it stays full. The room it counts includes words already requested and still in flight. A taken branch empties the queue and restarts fetching at the word that holds the target. If the target is the upper halfword of a word, the lower halfword of the first returned word is discarded. Responses to requests made before the branch still arrive on the bus, and they are dropped.

The bus side uses a request/ready handshake for addresses. Responses come back in order, at most one per cycle. The decoder side presents a valid instruction with its address, and the decoder consumes it by raising a take strobe.

Top module: `ifq_top`

## Requirements
- R1: The queue never holds more than six halfwords (three 32-bit words).
- R2: Each returned word supplies two halfwords in address order: bits [15:0] are the halfword at the word address and bits [31:16] are the halfword at the word address plus 2.
- R3: `req_valid` is high exactly when no branch is present, fewer than MAX_OUT requests are outstanding, and the held halfwords plus twice the live outstanding requests total at most four. `req_addr` is word aligned and advances by 4 per accepted request. It holds steady while a request waits for `req_ready`.
- R4: An instruction is 32 bits wide when bits [15:11] of its first halfword are 11101, 11110 or 11111, and 16 bits wide otherwise. `instr_is32` reports the width. `instr_data` is {16'h0000, first} for a narrow instruction and {second, first} for a wide one.
- R5: A wide instruction is not presented as valid until both of its halfwords are held.
- R6: A take while `instr_valid` is high removes the instruction, and `instr_pc` advances by 2 or 4 according to its width.
- R7: A branch empties the queue, blocks any request in that cycle, and ignores a take in that cycle. `instr_valid` is low in the following cycle, and the next request is for the target address with its two low bits cleared.
- R8: For a target with bit 1 set, the lower halfword of the first returned word is discarded, and the first instruction presented has `instr_pc` equal to the target.
- R9: Responses to requests made before a branch are discarded and never reach the decoder.
- R10: After reset `instr_valid` is low and the first request is for address RESET_ADDR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | output | 1 | Word fetch request |
| req_addr | output | AW | Word-aligned fetch address |
| req_ready | input | 1 | Bus accepts the request this cycle |
| resp_valid | input | 1 | Returned word valid (in request order) |
| resp_data | input | 32 | Returned word |
| branch_valid | input | 1 | Taken branch, flush and redirect |
| branch_addr | input | AW | Branch target (halfword address, bit 0 ignored) |
| instr_valid | output | 1 | Complete instruction at queue head |
| instr_is32 | output | 1 | Head instruction is 32 bits wide |
| instr_data | output | 32 | Head instruction bits |
| instr_pc | output | AW | Address of head instruction |
| instr_take | input | 1 | Decoder consumes the head instruction |

## Verification
On every cycle the assertions check the occupancy cap, the space reserved for in-flight words, the stability of a pending request, the flush timing after a branch and the step of the instruction address. Only the bench's scenarios can show that the right bits reach the decoder. This covers straddling wide instructions, odd-halfword targets, dropped stale responses and back-to-back branches. The bench compares every consumed instruction with a reference walk through a computed memory image.

// File: rtl/ifq_pkg.sv
// Shared constants and decode helper for the instruction fetch queue.
package ifq_pkg;
    localparam int HW_W  = 16;
    localparam int WORD_W = 32;

    // Returns 1 when a first halfword begins a 32-bit instruction.
    function automatic logic is_wide(input logic [HW_W-1:0] hw);
        return (hw[15:13] == 3'b111) && (hw[12:11] != 2'b00);
    endfunction
endpackage

// File: rtl/ifq_hw_queue.sv
// Halfword shift queue. Pops 0..2 halfwords from the head and appends
// 0..2 halfwords at the tail in the same cycle. The caller guarantees
// that pops never exceed the level and that pushes never overflow.
module ifq_hw_queue #(
    parameter int SLOTS = 6,
    localparam int LW = $clog2(SLOTS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic [1:0]    pop_n,
    input  logic [1:0]    push_n,
    input  logic [31:0]   push_word,
    output logic [LW-1:0] level,
    output logic [15:0]   head0,
    output logic [15:0]   head1
);
    logic [15:0]   slot_q [SLOTS];
    logic [15:0]   slot_d [SLOTS];
    logic [LW-1:0] level_d;

    // Shift out popped halfwords, then place pushed ones after the survivors.
    always_comb begin
        int mid;
        mid = int'(level) - int'(pop_n);
        for (int i = 0; i < SLOTS; i++) begin
            slot_d[i] = (i + int'(pop_n) < SLOTS) ? slot_q[i + int'(pop_n)] : '0;
            if (push_n != 2'd0 && i == mid)
                slot_d[i] = (push_n == 2'd2) ? push_word[15:0] : push_word[31:16];
            if (push_n == 2'd2 && i == mid + 1)
                slot_d[i] = push_word[31:16];
        end
        level_d = flush ? '0 : LW'(mid + int'(push_n));
    end

    // Register the slots and the level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= '0;
            for (int i = 0; i < SLOTS; i++) slot_q[i] <= '0;
        end else begin
            level <= level_d;
            for (int i = 0; i < SLOTS; i++) slot_q[i] <= slot_d[i];
        end
    end

    assign head0 = slot_q[0];
    assign head1 = slot_q[1];
endmodule

// File: rtl/ifq_fetch_ctrl.sv
// Fetch side: issues sequential word requests while space allows and
// tracks outstanding and stale responses. Responses are assumed to come
// back in request order, one per cycle at most.
module ifq_fetch_ctrl #(
    parameter int AW = 32,
    parameter int SLOTS = 6,
    parameter int MAX_OUT = 3,
    parameter logic [AW-1:0] RESET_ADDR = '0,
    localparam int LW = $clog2(SLOTS + 1),
    localparam int CW = $clog2(MAX_OUT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [LW-1:0] level,
    input  logic          branch_valid,
    input  logic [AW-1:0] branch_addr,
    input  logic          req_ready,
    input  logic          resp_valid,
    output logic          req_valid,
    output logic [AW-1:0] req_addr,
    output logic [1:0]    push_n,
    output logic [CW-1:0] inflight,
    output logic [CW-1:0] drop
);
    logic skip_lo;
    logic accept;
    logic live_resp;
    logic room;

    // Space test: held halfwords plus live outstanding words must leave one word free.
    always_comb begin
        room      = (int'(level) + 2 * (int'(inflight) - int'(drop))) <= SLOTS - 2;
        req_valid = room && !branch_valid && (int'(inflight) < MAX_OUT);
        accept    = req_valid && req_ready;
        live_resp = resp_valid && (drop == '0) && !branch_valid;
        push_n    = live_resp ? (skip_lo ? 2'd1 : 2'd2) : 2'd0;
    end

    // Track the address, the outstanding count, the stale count and the odd-target skip.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_addr <= {RESET_ADDR[AW-1:2], 2'b00};
            inflight <= '0;
            drop     <= '0;
            skip_lo  <= RESET_ADDR[1];
        end else begin
            inflight <= inflight + CW'(accept) - CW'(resp_valid);
            if (branch_valid) begin
                req_addr <= {branch_addr[AW-1:2], 2'b00};
                drop     <= inflight - CW'(resp_valid);
                skip_lo  <= branch_addr[1];
            end else begin
                if (accept)                    req_addr <= req_addr + AW'(4);
                if (resp_valid && drop != '0)  drop     <= drop - CW'(1);
                if (live_resp)                 skip_lo  <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/ifq_issue.sv
// Decoder side: checks the head instruction's width, presents it once it
// is complete, and tracks its address. A branch takes priority over a take.
module ifq_issue #(
    parameter int AW = 32,
    parameter int SLOTS = 6,
    parameter logic [AW-1:0] RESET_ADDR = '0,
    localparam int LW = $clog2(SLOTS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [LW-1:0] level,
    input  logic [15:0]   head0,
    input  logic [15:0]   head1,
    input  logic          instr_take,
    input  logic          branch_valid,
    input  logic [AW-1:0] branch_addr,
    output logic          instr_valid,
    output logic          instr_is32,
    output logic [31:0]   instr_data,
    output logic [AW-1:0] instr_pc,
    output logic [1:0]    pop_n
);
    import ifq_pkg::*;

    // Width check and completeness test on the head halfwords.
    always_comb begin
        instr_is32  = is_wide(head0);
        instr_valid = (level != '0) && (!instr_is32 || int'(level) >= 2);
        instr_data  = instr_is32 ? {head1, head0} : {16'h0000, head0};
        pop_n       = (instr_valid && instr_take && !branch_valid)
                      ? (instr_is32 ? 2'd2 : 2'd1) : 2'd0;
    end

    // Address of the head instruction.
    always_ff @(posedge clk) begin
        if (!rst_n)            instr_pc <= {RESET_ADDR[AW-1:1], 1'b0};
        else if (branch_valid) instr_pc <= {branch_addr[AW-1:1], 1'b0};
        else                   instr_pc <= instr_pc + AW'({pop_n, 1'b0});
    end
endmodule

// File: rtl/ifq_top.sv
// Instruction fetch queue top. It connects the fetch controller, the
// halfword queue and the issue stage. A branch flushes the queue and
// redirects fetching in the same cycle.
module ifq_top #(
    parameter int AW = 32,
    parameter int SLOTS = 6,
    parameter int MAX_OUT = 3,
    parameter logic [AW-1:0] RESET_ADDR = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic          req_valid,
    output logic [AW-1:0] req_addr,
    input  logic          req_ready,
    input  logic          resp_valid,
    input  logic [31:0]   resp_data,
    input  logic          branch_valid,
    input  logic [AW-1:0] branch_addr,
    output logic          instr_valid,
    output logic          instr_is32,
    output logic [31:0]   instr_data,
    output logic [AW-1:0] instr_pc,
    input  logic          instr_take
);
    localparam int LW = $clog2(SLOTS + 1);
    localparam int CW = $clog2(MAX_OUT + 1);

    logic [LW-1:0] level;
    logic [CW-1:0] inflight;
    logic [CW-1:0] drop;
    logic [1:0]    push_n;
    logic [1:0]    pop_n;
    logic [15:0]   head0;
    logic [15:0]   head1;

    ifq_fetch_ctrl #(.AW(AW), .SLOTS(SLOTS), .MAX_OUT(MAX_OUT), .RESET_ADDR(RESET_ADDR)) u_fetch (
        .clk(clk), .rst_n(rst_n), .level(level),
        .branch_valid(branch_valid), .branch_addr(branch_addr),
        .req_ready(req_ready), .resp_valid(resp_valid),
        .req_valid(req_valid), .req_addr(req_addr),
        .push_n(push_n), .inflight(inflight), .drop(drop)
    );

    ifq_hw_queue #(.SLOTS(SLOTS)) u_queue (
        .clk(clk), .rst_n(rst_n), .flush(branch_valid),
        .pop_n(pop_n), .push_n(push_n), .push_word(resp_data),
        .level(level), .head0(head0), .head1(head1)
    );

    ifq_issue #(.AW(AW), .SLOTS(SLOTS), .RESET_ADDR(RESET_ADDR)) u_issue (
        .clk(clk), .rst_n(rst_n), .level(level),
        .head0(head0), .head1(head1), .instr_take(instr_take),
        .branch_valid(branch_valid), .branch_addr(branch_addr),
        .instr_valid(instr_valid), .instr_is32(instr_is32),
        .instr_data(instr_data), .instr_pc(instr_pc), .pop_n(pop_n)
    );
endmodule

// File: rtl/ifq_checker.sv
// Property checker for ifq_top. It is bound into every instance and
// observes ports together with the occupancy counters.
module ifq_checker #(
    parameter int AW = 32,
    parameter int SLOTS = 6,
    parameter int MAX_OUT = 3,
    localparam int LW = $clog2(SLOTS + 1),
    localparam int CW = $clog2(MAX_OUT + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          branch_valid,
    input logic          req_valid,
    input logic          req_ready,
    input logic [AW-1:0] req_addr,
    input logic          instr_valid,
    input logic          instr_take,
    input logic          instr_is32,
    input logic [AW-1:0] instr_pc,
    input logic [LW-1:0] level,
    input logic [CW-1:0] inflight,
    input logic [CW-1:0] drop
);
    AST_LEVEL_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        int'(level) <= SLOTS); // R1
    AST_SPACE_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
        int'(level) + 2 * (int'(inflight) - int'(drop)) <= SLOTS); // R3
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready && !branch_valid |=>
            branch_valid || (req_valid && $stable(req_addr))); // R3
    AST_NO_REQ_ON_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
        branch_valid |-> !req_valid); // R7
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        branch_valid |=> !instr_valid); // R7
    AST_PC_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid && instr_take && !branch_valid |=>
            instr_pc == $past(instr_pc) + ($past(instr_is32) ? AW'(4) : AW'(2))); // R6
    AST_STALE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        drop <= inflight); // R9
endmodule

bind ifq_top ifq_checker #(.AW(AW), .SLOTS(SLOTS), .MAX_OUT(MAX_OUT)) u_chk (
    .clk(clk), .rst_n(rst_n), .branch_valid(branch_valid),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .instr_valid(instr_valid), .instr_take(instr_take),
    .instr_is32(instr_is32), .instr_pc(instr_pc),
    .level(level), .inflight(inflight), .drop(drop)
);

// File: tb/ifq_top_test.sv
// Bench for ifq_top. It includes a memory stub with fixed latency and
// random ready stalls, random takes and branches, and directed branches.
module ifq_top_test;
    localparam int AW = 32;
    localparam int MAX_OUT = 3;
    localparam int LAT = 3;
    localparam logic [AW-1:0] RST_A = 32'h0000_0100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid, req_ready = 1'b0;
    logic [AW-1:0] req_addr;
    logic resp_valid = 1'b0;
    logic [31:0] resp_data = '0;
    logic branch_valid = 1'b0;
    logic [AW-1:0] branch_addr = '0;
    logic instr_valid, instr_is32, instr_take = 1'b0;
    logic [31:0] instr_data;
    logic [AW-1:0] instr_pc;

    int checks = 0;
    int fails = 0;

    ifq_top #(.AW(AW), .MAX_OUT(MAX_OUT), .RESET_ADDR(RST_A)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_ready(req_ready), .resp_valid(resp_valid), .resp_data(resp_data),
        .branch_valid(branch_valid), .branch_addr(branch_addr),
        .instr_valid(instr_valid), .instr_is32(instr_is32),
        .instr_data(instr_data), .instr_pc(instr_pc), .instr_take(instr_take)
    );

    always #5 clk = ~clk;

    // Memory image: halfword contents hashed from the address, about 30 percent wide leaders.
    function automatic logic [15:0] mem_hw(input logic [31:0] a);
        logic [31:0] h;
        logic [4:0] top;
        h = {1'b0, a[31:1]} * 32'h9E37_79B1;
        h = h ^ (h >> 13);
        if (h % 10 < 3) top = 5'd29 + 5'(h[20:19] % 3);
        else            top = 5'(h[27:23] % 29);
        return {top, h[10:0]};
    endfunction

    function automatic logic wide_hw(input logic [15:0] hw);
        return hw[15:11] >= 5'd29;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Stub and reference state.
    logic [AW-1:0] q_addr [8];
    int q_due [8];
    int q_head = 0, q_tail = 0;
    int outstanding = 0, stale = 0, occ = 0;
    bit skip = 1'b0;
    logic [AW-1:0] exp_pc, exp_fetch;
    bit after_branch = 1'b0, first_after = 1'b0;
    bit odd_first = 1'b0;

    initial begin
        int cyc;
        int idle;
        bit done;
        void'($urandom(32'd4242));
        exp_pc = RST_A;
        exp_fetch = {RST_A[AW-1:2], 2'b00};
        skip = RST_A[1];
        repeat (4) @(posedge clk);
        #1;
        // R10: reset state
        check(instr_valid == 1'b0, "R10 instr_valid after reset", 64'(instr_valid), 0);
        check(req_addr == RST_A, "R10 first request address", 64'(req_addr), 64'(RST_A));
        @(negedge clk);
        rst_n = 1'b1;
        cyc = 0; idle = 0; done = 1'b0;
        while (!done) begin
            bit resp_now;
            bit br;
            logic [AW-1:0] tgt;
            @(negedge clk);
            cyc++;
            // R7: queue empty in the cycle after a branch.
            if (after_branch)
                check(instr_valid == 1'b0, "R7 instr_valid after branch", 64'(instr_valid), 0);
            after_branch = 1'b0;
            // Memory stub response.
            resp_now = (q_head != q_tail) && (q_due[q_head % 8] <= cyc);
            resp_valid = resp_now;
            resp_data = resp_now ? {mem_hw(q_addr[q_head % 8] + 2), mem_hw(q_addr[q_head % 8])} : '0;
            if (resp_now) q_head++;
            // Branch choice: directed ones, then random.
            br = 1'b0; tgt = '0;
            if (cyc == 150)      begin br = 1'b1; tgt = 32'h0000_2002; end // R8 odd target
            else if (cyc == 300) begin br = 1'b1; tgt = 32'h0000_3000; end
            else if (cyc == 301) begin br = 1'b1; tgt = 32'h0000_4006; end // back-to-back
            else if (cyc > 400 && $urandom % 40 == 0) begin
                br = 1'b1; tgt = 32'h0000_8000 + ((32'($urandom) % 32'h4000) & ~32'h1);
            end
            branch_valid = br;
            branch_addr = tgt;
            // R1, R3: request condition against reference occupancy.
            #1;
            check(occ <= 6, "R1 occupancy cap", 64'(occ), 6);
            if (!br)
                check(req_valid == ((occ + 2 * (outstanding - stale) <= 4) && outstanding < MAX_OUT),
                      "R3 request condition", 64'(req_valid), 64'(occ));
            // Take and compare with the reference walk.
            instr_take = 1'b0;
            if (!br && instr_valid && ($urandom % 10 < 7)) begin
                logic [15:0] f;
                logic [31:0] ed;
                bit w;
                instr_take = 1'b1;
                f = mem_hw(exp_pc);
                w = wide_hw(f);
                ed = w ? {mem_hw(exp_pc + 2), f} : {16'h0000, f};
                check(instr_pc == exp_pc, first_after ? (odd_first ? "R8 pc of first after odd target" : "R9 pc after flush") : "R6 instr_pc",
                      64'(instr_pc), 64'(exp_pc));
                check(instr_is32 == w, "R4 width decode", 64'(instr_is32), 64'(w));
                check(instr_data == ed, w ? "R5 R2 wide data" : "R2 R4 narrow data", 64'(instr_data), 64'(ed));
                exp_pc = exp_pc + (w ? 4 : 2);
                occ = occ - (w ? 2 : 1);
                first_after = 1'b0;
                idle = 0;
            end else if (br) begin
                instr_take = ($urandom % 2 == 0); // R7: ignored in a branch cycle
                idle = 0;
            end else idle++;
            // Response bookkeeping for the reference occupancy.
            if (resp_now) begin
                outstanding--;
                if (!br) begin
                    if (stale > 0) stale--;
                    else begin occ = occ + (skip ? 1 : 2); skip = 1'b0; end
                end
            end
            if (br) begin
                stale = outstanding; occ = 0; skip = tgt[1];
                exp_pc = {tgt[AW-1:1], 1'b0};
                exp_fetch = {tgt[AW-1:2], 2'b00};
                after_branch = 1'b1; first_after = 1'b1; odd_first = tgt[1];
            end
            // Bus acceptance.
            req_ready = ($urandom % 4 != 0);
            #1;
            if (req_valid && req_ready) begin
                check(req_addr == exp_fetch, "R3 R7 request address", 64'(req_addr), 64'(exp_fetch));
                exp_fetch = exp_fetch + 4;
                q_addr[q_tail % 8] = req_addr;
                q_due[q_tail % 8] = cyc + LAT;
                q_tail++;
                outstanding++;
            end
            if (idle > 2000) begin
                fails++; checks++;
                $display("FAIL watchdog: no progress actual=%0d expected=0", idle);
                done = 1'b1;
            end
            if (cyc >= 20000) done = 1'b1;
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule